// File: doc/BRIEF.md
# Byte-Serial Addressed RAM-Disk Controller

This controller lets a host processor reach a large banked byte store through a pair of byte-wide I/O registers. One register builds a 22-bit linear pointer by shifting in bytes. The other register reads or writes one byte at the pointer, and every access moves the pointer forward by one. The store is split into eight units. The top three pointer bits pick the unit and the remaining bits give the byte offset inside it.

Each unit has its own enable input and its own write-lock input. A disabled unit reads as an undriven bus (0xFF) and ignores writes. A locked unit ignores writes but can still be read. The pointer keeps advancing in every case, so a long block transfer walks straight across unit boundaries. The physical depth of each unit is a parameter (2^N bytes, N ≤ 19), which keeps simulation small. Pointer bits above N inside the offset field still count, but they do not select storage.

Top module: `rdisk_ctrl`

## Requirements
- R1: With `cs` high, `reg_sel`=1 addresses the pointer register and `reg_sel`=0 addresses the data register. When `cs` is low, strobes have no effect.
- R2: A write to the pointer register shifts the 22-bit pointer left by eight, drops the bits shifted above bit 21, and puts the written byte in bits 7:0. Three writes, most significant byte first, load a full pointer, and a fourth write pushes the oldest byte out.
- R3: A data access uses pointer bits 21:19 as the unit number and bits N-1:0 as the storage offset. Offset bits N through 18 are ignored for storage, so the offsets 0x40 and 0x00 alias when N=6.
- R4: Each data-register read or write adds one to the pointer after the access, modulo 2^22. A carry out of bit 18 moves the next access into the next unit, and 0x3FFFFF wraps to 0.
- R5: A read of the pointer register returns 0xFF and leaves the pointer unchanged.
- R6: A data read from a unit whose `unit_en` bit is 0 returns 0xFF, and the pointer still advances.
- R7: A data write to a unit whose `unit_wlock` bit is 1, or whose `unit_en` bit is 0, leaves the stored byte unchanged, and the pointer still advances.
- R8: Read data appears on `dout` in the cycle after the clock edge that samples the rising read strobe, and it holds until the next read.
- R9: A strobe held high for several clocks causes exactly one access and one pointer increment.
- R10: Synchronous active-low reset clears the pointer to 0 and sets `dout` to 0xFF. Reset does not clear stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for the register pair |
| rd | input | 1 | Read strobe, acted on at its rising edge |
| wr | input | 1 | Write strobe, acted on at its rising edge |
| reg_sel | input | 1 | 1 = pointer register, 0 = data register |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| unit_en | input | 8 | Per-unit enable |
| unit_wlock | input | 8 | Per-unit write lock |

## Verification
The hardest situations to reach are the pointer rollovers: the carry out of bit 18 into the next unit, and the wrap from 0x3FFFFF back to zero. Both need a full three-byte pointer load close to the boundary, followed by back-to-back data accesses. The bench checks them by reading back through a freshly reloaded pointer, because stored bytes are visible only through the data register. The protection paths need a further step. A byte is first written while its unit is open, then the unit is locked or disabled, and the byte is read again after the unit is reopened.

// File: rtl/rdisk_pkg.sv
// Shared constants and types for the RAM-disk controller.
// Assumes byte-wide host data and a 22-bit linear pointer split 3 + 19.
package rdisk_pkg;
    localparam int PTR_W    = 22;
    localparam int UNIT_W   = 3;
    localparam int OFFS_W   = PTR_W - UNIT_W;
    localparam int N_UNITS  = 1 << UNIT_W;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        PORT_DATA = 1'b0,
        PORT_PTR  = 1'b1
    } port_e;

    // one-cycle access request decoded from the host strobes
    typedef struct packed {
        logic  rd;
        logic  wr;
        port_e port;
        byte_t wdata;
    } access_t;
endpackage

// File: rtl/rdisk_host_if.sv
// Host strobe front end: turns chip-selected read/write levels into
// single-cycle access pulses at their rising edges.
// Assumes strobes are synchronous to clk; a write rising in the same
// cycle as a read takes precedence.
module rdisk_host_if
    import rdisk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs,
    input  logic    rd,
    input  logic    wr,
    input  logic    reg_sel,
    input  byte_t   din,
    output access_t acc
);
    logic rd_lvl, wr_lvl;
    logic rd_prev, wr_prev;

    assign rd_lvl = cs & rd;
    assign wr_lvl = cs & wr;

    // remember last strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_lvl;
            wr_prev <= wr_lvl;
        end
    end

    // build the access pulse, suppressed during reset
    always_comb begin
        acc.wr    = rst_n & wr_lvl & ~wr_prev;
        acc.rd    = rst_n & rd_lvl & ~rd_prev & ~acc.wr;
        acc.port  = reg_sel ? PORT_PTR : PORT_DATA;
        acc.wdata = din;
    end

    // R9
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc.rd |=> !acc.rd);
    // R9
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr |=> !acc.wr);
    // R1
    no_strobe_without_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !(acc.rd || acc.wr));
endmodule

// File: rtl/rdisk_ptr_reg.sv
// Linear pointer register: byte-shift load from the pointer port and
// post-increment after each data-port access.
// Assumes at most one access pulse per cycle.
module rdisk_ptr_reg
    import rdisk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  access_t          acc,
    output logic [PTR_W-1:0] ptr
);
    logic ptr_load;
    logic ptr_step;

    assign ptr_load = acc.wr && (acc.port == PORT_PTR);
    assign ptr_step = (acc.rd || acc.wr) && (acc.port == PORT_DATA);

    // shift-load or advance the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (ptr_load)
            ptr <= {ptr[PTR_W-9:0], acc.wdata};
        else if (ptr_step)
            ptr <= ptr + 1'b1;
    end

    // R2
    ptr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.wr && acc.port == PORT_PTR) |=>
            ptr == {$past(ptr[PTR_W-9:0]), $past(acc.wdata)});
    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc.rd || acc.wr) && acc.port == PORT_DATA) |=>
            ptr == $past(ptr) + 1'b1);
    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc.rd || acc.wr) |=> $stable(ptr));
endmodule

// File: rtl/rdisk_bank.sv
// Eight storage units with per-unit enable and write lock.
// Each unit holds 2^DEPTH_W bytes; reads are combinational from the
// current pointer, writes happen on the clock edge of the write pulse.
module rdisk_bank
    import rdisk_pkg::*;
#(
    parameter int DEPTH_W = 6
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_req,
    input  byte_t               wdata,
    input  logic [UNIT_W-1:0]   unit_sel,
    input  logic [DEPTH_W-1:0]  offs,
    input  logic [N_UNITS-1:0]  unit_en,
    input  logic [N_UNITS-1:0]  unit_wlock,
    output byte_t               rdata
);
    localparam int DEPTH = 1 << DEPTH_W;

    logic [N_UNITS-1:0] we;
    byte_t              unit_q [N_UNITS];

    // decode a write enable per unit, honouring enable and lock
    always_comb begin
        for (int u = 0; u < N_UNITS; u++)
            we[u] = wr_req && (unit_sel == u[UNIT_W-1:0])
                    && unit_en[u] && !unit_wlock[u];
    end

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        byte_t mem [DEPTH];

        // store one byte into this unit
        always_ff @(posedge clk) begin
            if (we[g])
                mem[offs] <= wdata;
        end

        assign unit_q[g] = mem[offs];
    end

    // select the addressed unit, undriven bus when disabled
    always_comb begin
        rdata = unit_en[unit_sel] ? unit_q[unit_sel] : 8'hFF;
    end

    // R3
    one_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));
    // R7
    locked_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_wlock[unit_sel] || !unit_en[unit_sel]) |-> (we == '0));
endmodule

// File: rtl/rdisk_ctrl.sv
// Top of the RAM-disk controller: host front end, pointer register,
// banked store and the registered read-data path.
// Assumes a single synchronous host; DEPTH_W sets bytes per unit.
module rdisk_ctrl
    import rdisk_pkg::*;
#(
    parameter int DEPTH_W = 6
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic       reg_sel,
    input  logic [7:0] din,
    output logic [7:0] dout,
    input  logic [7:0] unit_en,
    input  logic [7:0] unit_wlock
);
    initial begin
        if (DEPTH_W < 1 || DEPTH_W > OFFS_W)
            $error("DEPTH_W out of range");
    end

    access_t          acc;
    logic [PTR_W-1:0] ptr;
    byte_t            bank_q;
    logic             data_wr;

    rdisk_host_if u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .rd      (rd),
        .wr      (wr),
        .reg_sel (reg_sel),
        .din     (din),
        .acc     (acc)
    );

    rdisk_ptr_reg u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .ptr   (ptr)
    );

    assign data_wr = acc.wr && (acc.port == PORT_DATA);

    rdisk_bank #(.DEPTH_W(DEPTH_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (data_wr),
        .wdata      (acc.wdata),
        .unit_sel   (ptr[PTR_W-1 -: UNIT_W]),
        .offs       (ptr[DEPTH_W-1:0]),
        .unit_en    (unit_en),
        .unit_wlock (unit_wlock),
        .rdata      (bank_q)
    );

    // capture read data on a read pulse, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= 8'hFF;
        else if (acc.rd)
            dout <= (acc.port == PORT_PTR) ? 8'hFF : bank_q;
    end

    // R5
    ptr_port_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && acc.port == PORT_PTR) |=> dout == 8'hFF);
    // R6
    disabled_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && acc.port == PORT_DATA && !unit_en[ptr[PTR_W-1 -: UNIT_W]])
            |=> dout == 8'hFF);
    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc.rd || acc.wr) && acc.port == PORT_DATA && ptr == {PTR_W{1'b1}})
            |=> ptr == '0);
    // R8
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc.rd |=> $stable(dout));
endmodule

// File: tb/rdisk_ctrl_test.sv
module rdisk_ctrl_test;
    localparam int DW = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] unit_en = 8'hFF;
    logic [7:0] unit_wlock = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rdisk_ctrl #(.DEPTH_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr),
        .reg_sel(reg_sel), .din(din), .dout(dout),
        .unit_en(unit_en), .unit_wlock(unit_wlock)
    );

    // reference model
    logic [21:0] m_ptr = '0;
    logic [7:0]  m_mem [8 << DW];
    logic [7:0]  exp_q [$];
    string       tag_q [$];

    function automatic int idx(logic [21:0] a);
        return int'(a[21:19]) * (1 << DW) + int'(a[DW-1:0]);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic pulse_wr(logic sel, logic [7:0] b);
        @(negedge clk);
        cs = 1; wr = 1; reg_sel = sel; din = b;
        @(negedge clk);
        cs = 0; wr = 0;
    endtask

    task automatic set_ptr(logic [21:0] a);
        pulse_wr(1'b1, {2'b00, a[21:16]});
        pulse_wr(1'b1, a[15:8]);
        pulse_wr(1'b1, a[7:0]);
        m_ptr = a;
    endtask

    task automatic wr_data(logic [7:0] b);
        if (unit_en[m_ptr[21:19]] && !unit_wlock[m_ptr[21:19]])
            m_mem[idx(m_ptr)] = b;
        pulse_wr(1'b0, b);
        m_ptr = m_ptr + 1'b1;
    endtask

    task automatic rd_port(logic sel, string tag, int hold);
        logic [7:0] e;
        if (sel) e = 8'hFF;
        else begin
            e = unit_en[m_ptr[21:19]] ? m_mem[idx(m_ptr)] : 8'hFF;
            m_ptr = m_ptr + 1'b1;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        cs = 1; rd = 1; reg_sel = sel;
        repeat (hold) @(negedge clk);
        cs = 0; rd = 0;
    endtask

    // monitor: own edge detect on the read strobe, compare one cycle later
    logic rd_lvl_q = 0, take = 0;
    always @(posedge clk) begin
        take     <= rst_n && cs && rd && !rd_lvl_q && !(cs && wr);
        rd_lvl_q <= rst_n && cs && rd;
    end
    always @(negedge clk) begin
        if (take) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 actual=unexpected read expected=none");
            end else begin
                check(tag_q.pop_front(), dout, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 dout after reset", dout, 8'hFF);
        rst_n = 1;

        // R1/R3: basic writes and readback in unit 0
        set_ptr(22'h000010);
        wr_data(8'hA1); wr_data(8'hB2); wr_data(8'hC3);
        set_ptr(22'h000010);
        rd_port(0, "R1 data read", 1);
        rd_port(0, "R8 next byte", 1);
        rd_port(0, "R4 third byte", 1);

        // R5: pointer port read gives FF and does not move pointer
        set_ptr(22'h000011);
        rd_port(1, "R5 ptr port read", 1);
        rd_port(0, "R5 pointer unchanged", 1);

        // R2: fourth byte pushes the oldest out
        pulse_wr(1, 8'h3F); pulse_wr(1, 8'h00); pulse_wr(1, 8'h00); pulse_wr(1, 8'h12);
        m_ptr = 22'h000012;
        rd_port(0, "R2 four-byte load", 1);

        // R3: upper offset bits alias
        set_ptr(22'h000040 | 22'h5); wr_data(8'h5E);
        set_ptr(22'h000005);
        rd_port(0, "R3 offset alias", 1);

        // R4: carry into next unit
        set_ptr(22'h07FFFF); wr_data(8'h71); wr_data(8'h72);
        set_ptr(22'h080000);
        rd_port(0, "R4 carry into unit1", 1);
        set_ptr(22'h07FFFF);
        rd_port(0, "R4 end of unit0", 1);

        // R4: full wrap 3FFFFF -> 0
        set_ptr(22'h3FFFFF); wr_data(8'hE7); wr_data(8'h0A);
        set_ptr(22'h000000);
        rd_port(0, "R4 wrap to zero", 1);

        // R7: locked unit keeps its byte
        set_ptr(22'h100003); wr_data(8'h33);
        unit_wlock = 8'h04;
        set_ptr(22'h100003); wr_data(8'hCC); wr_data(8'h99);
        unit_wlock = 8'h00;
        set_ptr(22'h100003);
        rd_port(0, "R7 locked write ignored", 1);
        rd_port(0, "R7 pointer advanced past lock", 1);

        // R6/R7: disabled unit
        set_ptr(22'h300007); wr_data(8'h66); wr_data(8'h67);
        unit_en = 8'hBF;
        set_ptr(22'h300007); wr_data(8'h22);
        set_ptr(22'h300007);
        rd_port(0, "R6 disabled read", 1);
        unit_en = 8'hFF;
        rd_port(0, "R6 pointer advanced after disabled read", 1);
        set_ptr(22'h300007);
        rd_port(0, "R7 disabled write ignored", 1);

        // R9: held strobes give one access
        set_ptr(22'h000020); wr_data(8'h01); wr_data(8'h02);
        set_ptr(22'h000020);
        rd_port(0, "R9 held read", 4);
        rd_port(0, "R9 single increment", 1);

        // R1: strobes without cs ignored
        set_ptr(22'h000030); wr_data(8'h4D);
        @(negedge clk); cs = 0; wr = 1; reg_sel = 1; din = 8'h77;
        @(negedge clk); wr = 0;
        @(negedge clk); cs = 0; wr = 1; reg_sel = 0; din = 8'h88;
        @(negedge clk); wr = 0;
        m_ptr = 22'h000030;
        set_ptr(22'h000030);
        rd_port(0, "R1 no cs no effect", 1);

        // R10: reset clears pointer, keeps memory
        set_ptr(22'h000035);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        m_ptr = '0;
        wr_data(8'h5A);
        set_ptr(22'h000030);
        rd_port(0, "R10 memory kept", 1);
        set_ptr(22'h000000);
        rd_port(0, "R10 pointer cleared", 1);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R8 actual=%0d pending expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule